// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of up to 32 general-purpose pins, each with its own direction control and its own interrupt detector. A simple word-addressed register bus writes and reads the driven value, the drive enable, the trigger mode, the trigger polarity and the interrupt mask. It also reads the synchronised pin levels and the pending-event bits. A write-one-to-clear register acknowledges events.

Pin inputs pass through a two-flop synchroniser. Each pin detects either an edge or a level, and the polarity bit picks which edge or which level. A detection sets a sticky pending bit whatever the mask says. In level mode the pending bit is latched in the same way as an edge event. One registered interrupt line is raised while any unmasked pending bit is set.

Top module: `gpio_irq_bank`

## Requirements
- R1: `pin_out_o` shows the output-value register (offset 0x00) and `pin_oe_o` shows the output-enable register (offset 0x04), where 1 means the pin drives. A bus write changes the port on the clock edge that takes the write.
- R2: A read of offset 0x08 returns every pin's level after two synchroniser flops, whatever its direction. A change on `pin_in_i` becomes visible two clock edges later.
- R3: When a pin's mode bit (offset 0x0C) is 1, an edge between two successive synchronised samples sets its pending bit. A polarity bit (offset 0x10) of 1 selects the 0-to-1 edge and a polarity bit of 0 selects the 1-to-0 edge.
- R4: When the mode bit is 0, a synchronised sample equal to the polarity bit (1 for high, 0 for low) sets the pending bit in every cycle that it holds.
- R5: A read of offset 0x1C returns the pending bits. Pending bits set whatever the interrupt-enable bits are.
- R6: Writing 1 to a bit at offset 0x18 clears that pending bit on the edge that takes the write. Writing 0 leaves the bit unchanged. Reads of 0x18 return 0.
- R7: A level-mode pending bit stays set after the level goes away, until it is cleared. If the level is still active, the bit sets again in the next cycle.
- R8: `irq_o` is a register. At each edge it takes the OR over all pins of (pending AND interrupt-enable), where the enable register is at offset 0x14.
- R9: When a detection and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: All registers and outputs are 0 while `rst_ni` is low. Offsets 0x00, 0x04, 0x0C, 0x10 and 0x14 read back the last value written. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Read data for the addressed register, combinational |
| pin_in_i | input | NPINS | Asynchronous pin levels |
| pin_out_o | output | NPINS | Values to drive |
| pin_oe_o | output | NPINS | Drive enables |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
A wrong pending bit appears on the status read in the same cycle, and on `irq_o` one edge later if that pin is unmasked. A wrong previous-sample or synchroniser flop shows as an early, late or missing pending bit, two to three edges after the pin moves. The reference model is checked against the ports every cycle, so any of these faults is reported in the first cycle where it becomes visible. Directed phases stress level re-assertion after a clear and clears that land in the same cycle as a detection.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_OUT  = 3'd0,
    SEL_OE   = 3'd1,
    SEL_IN   = 3'd2,
    SEL_MODE = 3'd3,
    SEL_POL  = 3'd4,
    SEL_EN   = 3'd5,
    SEL_CLR  = 3'd6,
    SEL_STAT = 3'd7
  } reg_sel_e;

  function automatic reg_sel_e addr_sel(logic [ADDR_W-1:0] a);
    return reg_sel_e'(a[ADDR_W-1:2]);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] smp_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] det_o,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] pend_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall, lvl;
    assign rise = smp_i[g] & ~prev_q[g];
    assign fall = ~smp_i[g] & prev_q[g];
    assign lvl  = ~(smp_i[g] ^ pol_i[g]);
    assign det_o[g] = mode_i[g] ? (pol_i[g] ? rise : fall) : lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= smp_i;
      // a detection overrides a clear of the same bit
      pend_q <= (pend_q & ~clr_i) | det_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  in_val_i,
  input  logic [NPINS-1:0]  pend_i,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  oe_o,
  output logic [NPINS-1:0]  mode_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]  rdata_o
);
  reg_sel_e sel;
  logic [NPINS-1:0] out_q, oe_q, mode_q, pol_q, en_q;

  assign sel = addr_sel(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      oe_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_OUT:  out_q  <= wdata_i;
        SEL_OE:   oe_q   <= wdata_i;
        SEL_MODE: mode_q <= wdata_i;
        SEL_POL:  pol_q  <= wdata_i;
        SEL_EN:   en_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_i && sel == SEL_CLR) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_OUT:  rdata_o = out_q;
      SEL_OE:   rdata_o = oe_q;
      SEL_IN:   rdata_o = in_val_i;
      SEL_MODE: rdata_o = mode_q;
      SEL_POL:  rdata_o = pol_q;
      SEL_EN:   rdata_o = en_q;
      SEL_STAT: rdata_o = pend_i;
      default:  rdata_o = '0;
    endcase
  end

  assign out_o  = out_q;
  assign oe_o   = oe_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign en_o   = en_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_in_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [NPINS-1:0] smp_w, mode_w, pol_w, en_w, clr_w, det_w, pend_q;
  logic             irq_q;

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (smp_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) detect_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp_w),
    .mode_i (mode_w),
    .pol_i  (pol_w),
    .clr_i  (clr_w),
    .det_o  (det_w),
    .pend_o (pend_q)
  );

  gpio_irq_regfile #(.NPINS(NPINS)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .in_val_i (smp_w),
    .pend_i   (pend_q),
    .out_o    (pin_out_o),
    .oe_o     (pin_oe_o),
    .mode_o   (mode_w),
    .pol_o    (pol_w),
    .en_o     (en_w),
    .clr_o    (clr_w),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_q & en_w);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NPINS-1:0]  bus_wdata_i,
  input logic [NPINS-1:0]  bus_rdata_o,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  det_w,
  input logic [NPINS-1:0]  pend_q
);
  logic clr_hit;
  assign clr_hit = bus_wr_i && addr_sel(bus_addr_i) == SEL_CLR;

  assert_oe_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && addr_sel(bus_addr_i) == SEL_OE) |=> (pin_oe_o == $past(bus_wdata_i)));

  assert_clear_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && (det_w & bus_wdata_i) == '0) |=> ((pend_q & $past(bus_wdata_i)) == '0));

  assert_clr_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_sel(bus_addr_i) == SEL_CLR) |-> (bus_rdata_o == '0));

  assert_pend_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend_q & $past(pend_q)) & ~($past(bus_wdata_i) & {NPINS{$past(clr_hit)}})) == '0);

  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|pend_q));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|det_w) |=> ((pend_q & $past(det_w)) == $past(det_w)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) chk_i (.*);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [4:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] rdata, pin_out, pin_oe;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // reference model
  logic [N-1:0] m_out, m_oe, m_mode, m_pol, m_en, m_pend, m_s1, m_s2, m_prev;
  logic         m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_oe = '0; m_mode = '0; m_pol = '0; m_en = '0;
      m_pend = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 1'b0;
    end else begin
      logic [N-1:0] det, clr;
      det = '0;
      for (int i = 0; i < N; i++) begin
        if (m_mode[i]) det[i] = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        else           det[i] = (m_s2[i] == m_pol[i]);
      end
      clr = (wr && addr[4:2] == 3'd6) ? wdata : '0;
      m_irq  = (m_pend & m_en) != '0;
      m_pend = (m_pend & ~clr) | det;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin_in;
      if (wr) begin
        case (addr[4:2])
          3'd0: m_out  = wdata;
          3'd1: m_oe   = wdata;
          3'd3: m_mode = wdata;
          3'd4: m_pol  = wdata;
          3'd5: m_en   = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [N-1:0] model_rd(logic [4:0] a);
    case (a[4:2])
      3'd0: return m_out;
      3'd1: return m_oe;
      3'd2: return m_s2;
      3'd3: return m_mode;
      3'd4: return m_pol;
      3'd5: return m_en;
      3'd7: return m_pend;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a[4:2])
      3'd2: return "R2";
      3'd6: return "R6";
      3'd7: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", pin_out, m_out);
      check("R1", pin_oe, m_oe);
      check("R8", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
      check(tag_of(addr), rdata, model_rd(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic bus_write(logic [4:0] a, logic [N-1:0] d);
    @(posedge clk); #2;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] a, string tag);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    check(tag, rdata, model_rd(a));
  endtask

  task automatic drive_pins(logic [N-1:0] v);
    @(posedge clk); #2;
    pin_in = v;
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", pin_out, '0);
    check("R10", pin_oe, '0);
    check("R10", {{(N-1){1'b0}}, irq}, '0);
    check("R10", rdata, '0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R1, R10: register write and read-back
    bus_write(5'h00, 32'hA5A5_3C3C);
    bus_write(5'h04, 32'h0F0F_00FF);
    rd_chk(5'h00, "R1");
    rd_chk(5'h05, "R10");
    bus_write(5'h14, 32'h0000_0000);
    rd_chk(5'h14, "R10");

    // R2: input read after synchroniser, direction ignored
    drive_pins(32'h1234_5678);
    rd_chk(5'h08, "R2");
    repeat (2) @(posedge clk);
    rd_chk(5'h08, "R2");

    // R4, R7: default low-level mode latches; cleared bits re-set while active
    drive_pins('0);
    repeat (3) @(posedge clk);
    rd_chk(5'h1C, "R4");
    bus_write(5'h18, 32'hFFFF_FFFF);
    rd_chk(5'h1C, "R7");
    rd_chk(5'h18, "R6");

    // R3: edge mode, upper half falling, lower half rising
    bus_write(5'h10, 32'h0000_FFFF);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    repeat (3) @(posedge clk);
    bus_write(5'h18, 32'hFFFF_FFFF);
    rd_chk(5'h1C, "R3");
    drive_pins(32'hFFFF_FFFF);
    repeat (4) @(posedge clk);
    rd_chk(5'h1C, "R3");
    drive_pins(32'h0000_0000);
    repeat (4) @(posedge clk);
    rd_chk(5'h1C, "R3");

    // R6: writing zeros leaves pending; R5/R8: enable masks irq
    bus_write(5'h18, 32'h0000_0000);
    rd_chk(5'h1C, "R6");
    bus_write(5'h14, 32'h0000_0001);
    repeat (2) @(posedge clk);
    rd_chk(5'h1C, "R8");
    bus_write(5'h18, 32'h0000_0001);
    repeat (2) @(posedge clk);
    rd_chk(5'h1C, "R5");

    // R7: high-level on pin 4, level removed, bit stays until cleared
    bus_write(5'h0C, 32'hFFFF_FFEF);
    bus_write(5'h10, 32'h0000_0010);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_write(5'h14, 32'h0000_0010);
    drive_pins(32'h0000_0010);
    repeat (4) @(posedge clk);
    drive_pins(32'h0000_0000);
    repeat (4) @(posedge clk);
    rd_chk(5'h1C, "R7");
    bus_write(5'h18, 32'h0000_0010);
    rd_chk(5'h1C, "R7");

    // R9: clears every cycle while pin 3 toggles
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #2;
      wr = 1'b1; addr = 5'h18; wdata = 32'hFFFF_FFFF;
      if (k % 3 == 0) pin_in = pin_in ^ 32'h0000_0008;
      @(negedge clk);
      check("R9", rdata, model_rd(5'h18));
    end
    @(posedge clk); #2 wr = 1'b0;
    rd_chk(5'h1C, "R9");

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #2;
      wr    = ($urandom % 3) == 0;
      addr  = 5'(($urandom % 8) * 4 + ($urandom % 4));
      wdata = $urandom;
      if (($urandom % 4) == 0) pin_in = $urandom;
    end
    @(posedge clk); #2 wr = 1'b0;
    rd_chk(5'h1C, "R5");
    repeat (3) @(posedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule